// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches three 8-bit general-purpose input ports, called A, B and F, and turns selected pin activity into interrupt requests. Each line has three configuration bits. A mode bit chooses level or edge sensing. A polarity bit chooses low/falling or high/rising. An enable bit gates the line. Edge events are held in a per-line latch until software acknowledges them. Software acknowledges a line by writing a one to its bit of the port's acknowledge register. Level conditions are not latched: they follow the synchronised pin.

The pins pass through a two-flop synchroniser before any detection. Ports A and B share one combined request output. Software reads each port's status register to find which lines are active. Port F drives one request output per line. Software reconfigures a line in a fixed order:

1. Clear the enable.
2. Set the polarity.
3. Set the mode.
4. Write the enable again.

Nothing is latched while a line is disabled, so changing the configuration cannot create a false event.

The register interface is a simple single-cycle write strobe with an 8-bit byte address. Read data is combinational from the byte address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every configuration register, latch and synchroniser stage is 0, and `irq_ab` and `irq_f` are 0.
- R2: A line in level mode (mode bit 0) is pending while it is enabled and its synchronised pin equals the polarity bit (0 = low, 1 = high). A pin change is visible at the outputs after the second rising clock edge.
- R3: A line in edge mode (mode bit 1) latches a rising edge when the polarity bit is 1 and a falling edge when it is 0. The edge is detected against the previous synchronised sample, and the request appears after the third rising clock edge that follows the pin change. The request stays set after the pin returns, and an edge of the other direction does not set it.
- R4: Writing the acknowledge register clears every latched line whose data bit is 1. Lines whose data bit is 0 are not affected.
- R5: An acknowledge write to a level-mode line has no lasting effect; the line stays pending while its condition holds.
- R6: If an edge event and an acknowledge of the same line take effect on the same clock edge, the line stays pending.
- R7: A disabled line never reports pending and never latches an edge. Clearing the enable drops any latch, and enabling the line again does not bring back an old event.
- R8: `irq_ab` is the OR of all eight status bits of port A and all eight of port B. `irq_f[i]` is status bit i of port F. Port F activity never drives `irq_ab`.
- R9: The byte addresses are as follows. Port A: mode 0x90, polarity 0x94, acknowledge 0x98, enable 0x9c, status 0xa0. Port B: mode 0xac, polarity 0xb0, acknowledge 0xb4, enable 0xb8, status 0xbc. Port F: mode 0x4c, polarity 0x50, acknowledge 0x54, enable 0x5c, status 0x58. Mode, polarity and enable read back as written. The acknowledge register reads 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 8 | Asynchronous port A pins |
| pin_b | input | 8 | Asynchronous port B pins |
| pin_f | input | 8 | Asynchronous port F pins |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address for reads and writes |
| bus_wdata | input | 8 | Register write data, one bit per line |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_ab | output | 1 | Combined request of ports A and B |
| irq_f | output | 8 | Per-line requests of port F |

## Verification
The assertions check three things on every cycle. No disabled line drives a request. The combined output is never raised while ports A and B have no enabled line. A latched edge-mode line stays pending until a register write to its own port. The bench scenarios alone cover the exact latencies of level and edge sensing, which edge direction is chosen, and acknowledge masks with mixed bits. They also cover the same-cycle collision of an event with an acknowledge, and the guarantee that a re-enabled line does not bring back a stale event. A behavioural reference model of all three ports is compared against both outputs on every clock throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int LINES = 8;
    localparam int NPORT = 3;
    localparam int AW    = 8;

    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_F = 2'd2
    } port_e;

    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_POL  = 3'd1,
        REG_ACK  = 3'd2,
        REG_EN   = 3'd3,
        REG_STS  = 3'd4
    } reg_e;

    // Per-port line configuration carried as one record
    typedef struct packed {
        logic [LINES-1:0] edge_mode;
        logic [LINES-1:0] pol_high;
        logic [LINES-1:0] enable;
    } line_cfg_t;

    // Per-port detector output
    typedef struct packed {
        logic [LINES-1:0] edge_hit;
        logic [LINES-1:0] level_hit;
    } detect_t;

    // Byte address of one register of one port; software relies on these
    function automatic logic [AW-1:0] reg_ofs(input port_e port, input reg_e r);
        logic [AW-1:0] ofs;
        ofs = '0;
        case (port)
            PORT_A: case (r)
                REG_MODE: ofs = 8'h90;
                REG_POL:  ofs = 8'h94;
                REG_ACK:  ofs = 8'h98;
                REG_EN:   ofs = 8'h9c;
                default:  ofs = 8'ha0;
            endcase
            PORT_B: case (r)
                REG_MODE: ofs = 8'hac;
                REG_POL:  ofs = 8'hb0;
                REG_ACK:  ofs = 8'hb4;
                REG_EN:   ofs = 8'hb8;
                default:  ofs = 8'hbc;
            endcase
            default: case (r)
                REG_MODE: ofs = 8'h4c;
                REG_POL:  ofs = 8'h50;
                REG_ACK:  ofs = 8'h54;
                REG_EN:   ofs = 8'h5c;
                default:  ofs = 8'h58;
            endcase
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage [STAGES];
    logic [W-1:0] hold;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[k] <= '0;
                end else if (k == 0) begin
                    stage[k] <= pin;
                end else begin
                    stage[k] <= stage[(k == 0) ? 0 : k-1];
                end
            end
        end
    endgenerate

    // Previous synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else begin
            hold <= stage[LAST];
        end
    end

    assign cur  = stage[LAST];
    assign prev = hold;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  line_cfg_t        cfg,
    input  logic [LINES-1:0] cur,
    input  logic [LINES-1:0] prev,
    output detect_t          det
);
    logic [LINES-1:0] rise;
    logic [LINES-1:0] fall;
    logic [LINES-1:0] armed;

    always_comb begin
        rise  = cur & ~prev;
        fall  = ~cur & prev;
        armed = cfg.enable & cfg.edge_mode;
        det.edge_hit  = armed & ((cfg.pol_high & rise) | (~cfg.pol_high & fall));
        det.level_hit = ~(cur ^ cfg.pol_high);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter port_e PORT = PORT_A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [LINES-1:0] bus_wdata,
    output logic [LINES-1:0] rdata,
    output logic [LINES-1:0] status,
    output line_cfg_t        cfg_out
);
    localparam logic [AW-1:0] A_MODE = reg_ofs(PORT, REG_MODE);
    localparam logic [AW-1:0] A_POL  = reg_ofs(PORT, REG_POL);
    localparam logic [AW-1:0] A_ACK  = reg_ofs(PORT, REG_ACK);
    localparam logic [AW-1:0] A_EN   = reg_ofs(PORT, REG_EN);
    localparam logic [AW-1:0] A_STS  = reg_ofs(PORT, REG_STS);

    line_cfg_t        cfg;
    detect_t          det;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;
    logic [LINES-1:0] latch_q;
    logic [LINES-1:0] latch_d;
    logic [LINES-1:0] ack_mask;

    gpio_irq_sync #(.W(LINES), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin),
        .cur  (cur),
        .prev (prev)
    );

    gpio_irq_detect u_det (
        .cfg  (cfg),
        .cur  (cur),
        .prev (prev),
        .det  (det)
    );

    always_comb begin
        ack_mask = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
        // New event wins over a same-cycle acknowledge; disabled or
        // level-mode lines hold nothing
        latch_d  = cfg.enable & cfg.edge_mode & ((latch_q & ~ack_mask) | det.edge_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
            if (bus_wr) begin
                if (bus_addr == A_MODE) cfg.edge_mode <= bus_wdata;
                if (bus_addr == A_POL)  cfg.pol_high  <= bus_wdata;
                if (bus_addr == A_EN)   cfg.enable    <= bus_wdata;
            end
        end
    end

    always_comb begin
        status = cfg.enable & ((cfg.edge_mode & latch_q) | (~cfg.edge_mode & det.level_hit));
        unique case (bus_addr)
            A_MODE:  rdata = cfg.edge_mode;
            A_POL:   rdata = cfg.pol_high;
            A_EN:    rdata = cfg.enable;
            A_STS:   rdata = status;
            default: rdata = '0;
        endcase
    end

    assign cfg_out = cfg;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   pin_a,
    input  logic [7:0]   pin_b,
    input  logic [7:0]   pin_f,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    output logic         irq_ab,
    output logic [7:0]   irq_f
);
    logic [NPORT-1:0][LINES-1:0] pins_all;
    logic [NPORT-1:0][LINES-1:0] rd_all;
    logic [NPORT-1:0][LINES-1:0] sts_all;
    logic [NPORT-1:0][LINES-1:0] en_all;
    logic [NPORT-1:0][LINES-1:0] edge_all;
    line_cfg_t                   cfg_all [NPORT];

    assign pins_all[PORT_A] = pin_a;
    assign pins_all[PORT_B] = pin_b;
    assign pins_all[PORT_F] = pin_f;

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_bank
            gpio_irq_bank #(.PORT(port_e'(g))) u_bank (
                .clk       (clk),
                .rst       (rst),
                .pin       (pins_all[g]),
                .bus_wr    (bus_wr),
                .bus_addr  (bus_addr),
                .bus_wdata (bus_wdata),
                .rdata     (rd_all[g]),
                .status    (sts_all[g]),
                .cfg_out   (cfg_all[g])
            );
            assign en_all[g]   = cfg_all[g].enable;
            assign edge_all[g] = cfg_all[g].edge_mode;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            bus_rdata = bus_rdata | rd_all[p];
        end
    end

    assign irq_ab = |{sts_all[PORT_A], sts_all[PORT_B]};
    assign irq_f  = sts_all[PORT_F];
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        irq_ab,
    input logic [LINES-1:0]            irq_f,
    input logic                        bus_wr,
    input logic [AW-1:0]               bus_addr,
    input logic [NPORT-1:0][LINES-1:0] sts_all,
    input logic [NPORT-1:0][LINES-1:0] en_all,
    input logic [NPORT-1:0][LINES-1:0] edge_all
);
    logic [NPORT-1:0] port_wr;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            port_wr[p] = bus_wr &&
                (bus_addr == reg_ofs(port_e'(p), REG_MODE) ||
                 bus_addr == reg_ofs(port_e'(p), REG_POL)  ||
                 bus_addr == reg_ofs(port_e'(p), REG_ACK)  ||
                 bus_addr == reg_ofs(port_e'(p), REG_EN));
        end
    end

    // R7
    f_line_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_f & ~en_all[PORT_F]) == '0);

    // R7
    ab_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ab |-> ((en_all[PORT_A] | en_all[PORT_B]) != '0));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_f == '0 && !irq_ab));

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            for (genvar i = 0; i < LINES; i++) begin : g_line
                // R3
                edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
                    (edge_all[p][i] && sts_all[p][i] && !port_wr[p]) |=> sts_all[p][i]);
            end
        end
    endgenerate
endmodule

bind gpio_irq_port gpio_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_ab   (irq_ab),
    .irq_f    (irq_f),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .sts_all  (sts_all),
    .en_all   (en_all),
    .edge_all (edge_all)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/100ps
module tb_gpio_irq_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_ab;
    logic [7:0] irq_f;

    gpio_irq_port dut (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .pin_f(pin_f),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    always #2.5 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string phase  = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Independent address table: index 0 mode, 1 polarity, 2 ack, 3 enable, 4 status
    function automatic logic [7:0] addr_of(input int p, input int k);
        logic [7:0] ta [5] = '{8'h90, 8'h94, 8'h98, 8'h9c, 8'ha0};
        logic [7:0] tb [5] = '{8'hac, 8'hb0, 8'hb4, 8'hb8, 8'hbc};
        logic [7:0] tf [5] = '{8'h4c, 8'h50, 8'h54, 8'h5c, 8'h58};
        if (p == 0) return ta[k];
        if (p == 1) return tb[k];
        return tf[k];
    endfunction

    // Behavioural reference: per-port configuration, latches and pin history
    logic [7:0] m_mode [3], m_pol [3], m_en [3], m_lat [3];
    logic [7:0] hist [3][3];   // [0] newest sample, [2] oldest

    function automatic logic [7:0] pin_of(input int p);
        return (p == 0) ? pin_a : (p == 1) ? pin_b : pin_f;
    endfunction

    function automatic logic [7:0] exp_status(input int p);
        logic [7:0] lvl;
        lvl = ~(hist[p][1] ^ m_pol[p]);
        return m_en[p] & ((m_mode[p] & m_lat[p]) | (~m_mode[p] & lvl));
    endfunction

    always @(posedge clk) begin
        logic [7:0] s, q, ev, clr;
        for (int p = 0; p < 3; p++) begin
            if (rst) begin
                m_mode[p] = '0; m_pol[p] = '0; m_en[p] = '0; m_lat[p] = '0;
                for (int k = 0; k < 3; k++) hist[p][k] = '0;
            end else begin
                s   = hist[p][1];
                q   = hist[p][2];
                ev  = (m_pol[p] & s & ~q) | (~m_pol[p] & ~s & q);
                clr = (bus_wr && bus_addr == addr_of(p, 2)) ? bus_wdata : 8'h00;
                m_lat[p] = m_en[p] & m_mode[p] & ((m_lat[p] & ~clr) | ev);
                if (bus_wr && bus_addr == addr_of(p, 0)) m_mode[p] = bus_wdata;
                if (bus_wr && bus_addr == addr_of(p, 1)) m_pol[p]  = bus_wdata;
                if (bus_wr && bus_addr == addr_of(p, 3)) m_en[p]   = bus_wdata;
                hist[p][2] = hist[p][1];
                hist[p][1] = hist[p][0];
                hist[p][0] = pin_of(p);
            end
        end
    end

    // Per-cycle comparison against the reference (R8 output composition)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(irq_ab === |{exp_status(0), exp_status(1)}, {phase, "/R8"},
                  "irq_ab vs model", int'(irq_ab), int'(|{exp_status(0), exp_status(1)}));
            check(irq_f === exp_status(2), {phase, "/R8"}, "irq_f vs model",
                  int'(irq_f), int'(exp_status(2)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #0.5;
        check(bus_rdata === exp, req, $sformatf("read 0x%0h", a), int'(bus_rdata), int'(exp));
        bus_addr = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        phase = "R1";
        check(irq_ab === 1'b0, "R1", "irq_ab after reset", int'(irq_ab), 0);
        check(irq_f === 8'h00, "R1", "irq_f after reset", int'(irq_f), 0);
        rd_chk(8'h9c, 8'h00, "R1");
        rd_chk(8'h50, 8'h00, "R1");

        // R9 address map and readback
        phase = "R9";
        wr(8'h90, 8'h5a); rd_chk(8'h90, 8'h5a, "R9"); wr(8'h90, 8'h00);
        wr(8'hb0, 8'h3c); rd_chk(8'hb0, 8'h3c, "R9"); wr(8'hb0, 8'h00);
        wr(8'h54, 8'hff); rd_chk(8'h54, 8'h00, "R9");
        rd_chk(8'h77, 8'h00, "R9");

        // R2 level sensing on port F: bit0 high, bit1 low
        phase = "R2";
        wr(8'h4c, 8'h00); wr(8'h50, 8'h01); wr(8'h5c, 8'h03);
        tick(2);
        check(irq_f === 8'h02, "R2", "level-low pending", int'(irq_f), 8'h02);
        check(irq_ab === 1'b0, "R8", "port F kept off irq_ab", int'(irq_ab), 0);
        pin_f = 8'h03;
        tick(1);
        check(irq_f === 8'h02, "R2", "one edge after pin change", int'(irq_f), 8'h02);
        tick(1);
        check(irq_f === 8'h01, "R2", "level-high after two edges", int'(irq_f), 8'h01);
        rd_chk(8'h58, 8'h01, "R9");

        // R5 acknowledge on a level line
        phase = "R5";
        wr(8'h54, 8'h01);
        tick(1);
        check(irq_f[0] === 1'b1, "R5", "level line after ack", int'(irq_f[0]), 1);

        // R7 disable gating and latch drop
        phase = "R7";
        wr(8'h5c, 8'h00);
        check(irq_f === 8'h00, "R7", "all disabled", int'(irq_f), 0);
        pin_f = 8'h00;
        wr(8'h4c, 8'h08); wr(8'h50, 8'h08);
        pin_f = 8'h08;
        tick(4);
        wr(8'h5c, 8'h08);
        tick(1);
        check(irq_f === 8'h00, "R7", "edge while disabled not latched", int'(irq_f), 0);
        phase = "R3";
        pin_f = 8'h00; tick(3);
        check(irq_f === 8'h00, "R3", "falling ignored in rising mode", int'(irq_f), 0);
        pin_f = 8'h08; tick(3);
        check(irq_f === 8'h08, "R3", "rising latched", int'(irq_f), 8'h08);
        phase = "R7";
        wr(8'h5c, 8'h00); wr(8'h5c, 8'h08);
        check(irq_f === 8'h00, "R7", "re-enable drops old event", int'(irq_f), 0);
        wr(8'h5c, 8'h00);

        // R3 rising edge on port A bit2
        phase = "R3";
        wr(8'h90, 8'h04); wr(8'h94, 8'h04); wr(8'h9c, 8'h04);
        pin_a = 8'h04;
        tick(2);
        check(irq_ab === 1'b0, "R3", "not yet after two edges", int'(irq_ab), 0);
        tick(1);
        check(irq_ab === 1'b1, "R3", "latched after third edge", int'(irq_ab), 1);
        pin_a = 8'h00;
        tick(4);
        check(irq_ab === 1'b1, "R3", "held after pin returns", int'(irq_ab), 1);
        rd_chk(8'ha0, 8'h04, "R8");

        // R4 acknowledge masks
        phase = "R4";
        wr(8'h98, 8'hfb);
        tick(1);
        check(irq_ab === 1'b1, "R4", "zero bit leaves line", int'(irq_ab), 1);
        wr(8'h98, 8'h04);
        check(irq_ab === 1'b0, "R4", "one bit clears line", int'(irq_ab), 0);
        wr(8'h9c, 8'h00);

        // R6 collision on port B bit7, falling mode
        phase = "R6";
        pin_b = 8'h80; tick(4);
        wr(8'hb0, 8'h00); wr(8'hac, 8'h80); wr(8'hb8, 8'h80);
        pin_b = 8'h00; tick(3);
        check(irq_ab === 1'b1, "R3", "falling latched on B", int'(irq_ab), 1);
        wr(8'hb4, 8'h80);
        check(irq_ab === 1'b0, "R4", "B acknowledged", int'(irq_ab), 0);
        pin_b = 8'h80; tick(4);
        check(irq_ab === 1'b0, "R3", "rising ignored in falling mode", int'(irq_ab), 0);
        pin_b = 8'h00; tick(2);
        wr(8'hb4, 8'h80);
        check(irq_ab === 1'b1, "R6", "event beats same-cycle ack", int'(irq_ab), 1);
        tick(2);
        check(irq_ab === 1'b1, "R6", "still pending later", int'(irq_ab), 1);
        rd_chk(8'hbc, 8'h80, "R8");
        wr(8'hb4, 8'h80);
        check(irq_ab === 1'b0, "R4", "final ack", int'(irq_ab), 0);
        wr(8'hb8, 8'h00);
        tick(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule